// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block takes an external interrupt request on an 8-bit digital input port and reports it through a small register port. Software sets a configuration word that turns interrupt service on, picks the active edge of the request, and chooses whether the port value should be captured when the interrupt fires. While interrupt service is off, all eight port pins are ordinary inputs. While it is on, the two highest pins change role. Bit 6 becomes the request line and bit 7 becomes an active-low gate.

A qualifying edge sets a pending flag, raises the interrupt output and, if capture is selected, stores the synchronized port value. Another qualifying edge that arrives while the flag is still set is recorded in a missed flag. It does not disturb the captured data. Software clears each flag by writing one to it. All input pins pass through a two-stage synchronizer before any edge is detected.

The register port has a 2-bit address. Address 0 is the control/status word. Address 1 holds the captured port data. Address 2 gives the live synchronized port. Address 3 reads as zero. Read data is registered, so it appears one clock after the address is presented. Control/status bit positions are: capture enable 5, edge select 6, interrupt service enable 12, pending 17, missed 23. All other bits read as 0.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the control/status word, the captured data and the interrupt output are all 0.
- R2: Bits 5, 6 and 12 of the control/status word can be read and written. Every other bit reads as 0, except the hardware flags 17 and 23.
- R3: While bit 12 is 0, request edges on port bit 6 never set pending, and the live port read (address 2) shows all eight synchronized pins.
- R4: While bit 12 is 1, the live port read shows bits 6 and 7 as 0 and the other six pins unchanged.
- R5: With bit 6 = 0, a rising edge of the request sets pending (bit 17), and a falling edge does not.
- R6: With bit 6 = 1, a falling edge of the request sets pending, and a rising edge does not.
- R7: A request edge that arrives while port bit 7 (the active-low gate) is high is ignored.
- R8: Writing 1 to bit 17 clears pending. Writing 0 to bit 17 leaves it unchanged. Software can never set it.
- R9: A qualifying edge while pending is already 1 sets missed (bit 23). Writing 1 to bit 23 clears missed, and writing 0 leaves it unchanged.
- R10: Capture mode {bit 6, bit 5}: 01 captures on the rising edge and 11 on the falling edge. 00 and 10 capture nothing. The captured value is the synchronized port and appears at address 1 and on the captured-data output.
- R11: Edges that arrive while pending is 1 do not change the captured data.
- R12: The interrupt output is pending AND bit 12. Clearing bit 12 drops the output but keeps pending.
- R13: If a write-one clear of pending and a new qualifying edge land in the same cycle, pending stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control/status, 1 captured data, 2 live port) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| port_in | input | 8 | Asynchronous input port; bits 6 and 7 serve as request and gate when enabled |
| port_latched | output | 8 | Captured port data |
| irq | output | 1 | Interrupt output |

## Verification
The hardest condition to reach is the cycle in which a software clear of pending and a fresh qualifying edge land on the same clock. The request travels through two synchronizer flops and an edge register before it can set the flag. The stimulus therefore changes the request on a falling clock edge and waits two more falling edges. It then raises the write strobe, so the write is sampled on the same rising edge that the detected edge is. The missed-edge case is reached by sending a second falling edge before any clear. The check then confirms that the captured value from the first edge survives.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  // Control/status bit positions (software decodes these)
  localparam int CAP_BIT  = 5;
  localparam int POL_BIT  = 6;
  localparam int EN_BIT   = 12;
  localparam int PEND_BIT = 17;
  localparam int MISS_BIT = 23;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CAPT = 2'd1;
  localparam logic [1:0] ADDR_LIVE = 2'd2;

  typedef struct packed {
    logic en;
    logic pol;
    logic cap;
  } irq_cfg_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic gate_n,
  input  logic en,
  input  logic pol,
  output logic hit
);
  logic req_prev;
  logic rise, fall, sel_edge;

  always_ff @(posedge clk) begin
    if (rst) req_prev <= 1'b0;
    else     req_prev <= req;
  end

  assign rise     = req & ~req_prev;
  assign fall     = ~req & req_prev;
  assign sel_edge = pol ? fall : rise;
  assign hit      = sel_edge & en & ~gate_n;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  input  logic [PORT_W-1:0] port_sync,
  output irq_cfg_t          cfg,
  output logic              pend,
  output logic              missed,
  output logic [PORT_W-1:0] captured
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_ctrl) begin
      cfg.en  <= wdata[EN_BIT];
      cfg.pol <= wdata[POL_BIT];
      cfg.cap <= wdata[CAP_BIT];
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      missed <= 1'b0;
    end else begin
      if (hit)                           pend <= 1'b1;
      else if (wr_ctrl && wdata[PEND_BIT]) pend <= 1'b0;
      if (hit && pend)                   missed <= 1'b1;
      else if (wr_ctrl && wdata[MISS_BIT]) missed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      captured <= '0;
    else if (hit && !pend && cfg.cap) captured <= port_sync;
  end

  // R3
  pend_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(cfg.en));
  // R8
  w1c_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_ctrl) && $past(wdata[PEND_BIT]) && !$past(hit)) |-> !pend);
  // R9
  missed_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(missed) |-> ($past(hit) && $past(pend)));
  // R11
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pend) |-> $stable(captured));
  // R13
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(hit) |-> pend);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [PORT_W-1:0] port_in,
  output logic [PORT_W-1:0] port_latched,
  output logic              irq
);
  localparam int REQ_IDX  = PORT_W - 2;
  localparam int GATE_IDX = PORT_W - 1;

  logic [PORT_W-1:0] port_sync;
  logic [PORT_W-1:0] live_view;
  logic              hit, pend, missed, wr_ctrl;
  irq_cfg_t          cfg;
  logic [DATA_W-1:0] ctrl_word, rd_next;

  ext_irq_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(port_in), .q(port_sync)
  );

  ext_irq_edge u_edge (
    .clk(clk), .rst(rst),
    .req(port_sync[REQ_IDX]), .gate_n(port_sync[GATE_IDX]),
    .en(cfg.en), .pol(cfg.pol), .hit(hit)
  );

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

  ext_irq_regs #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .hit(hit), .port_sync(port_sync), .cfg(cfg), .pend(pend),
    .missed(missed), .captured(port_latched)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CAP_BIT]  = cfg.cap;
    ctrl_word[POL_BIT]  = cfg.pol;
    ctrl_word[EN_BIT]   = cfg.en;
    ctrl_word[PEND_BIT] = pend;
    ctrl_word[MISS_BIT] = missed;
  end

  always_comb begin
    live_view = port_sync;
    if (cfg.en) begin
      live_view[REQ_IDX]  = 1'b0;
      live_view[GATE_IDX] = 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: rd_next = ctrl_word;
      ADDR_CAPT: rd_next = DATA_W'(port_latched);
      ADDR_LIVE: rd_next = DATA_W'(live_view);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assign irq = pend & cfg.en;

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(hit) || $rose(cfg.en)));
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0]  port_in = 0, port_latched;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t exp_q[$];
  event sample_ev;

  ext_irq_ctrl dut (.clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_in(port_in),
    .port_latched(port_latched), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items and compares them with outputs
  initial forever begin
    @(sample_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? {31'd0, irq} : {24'd0, port_latched};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic settle(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] e, string r);
    item_t it;
    @(negedge clk); reg_addr = a;
    @(negedge clk);
    it.kind = 0; it.exp = e; it.req = r;
    exp_q.push_back(it); -> sample_ev;
    #1;
  endtask

  task automatic pin(int k, logic [31:0] e, string r);
    item_t it;
    @(negedge clk);
    it.kind = k; it.exp = e; it.req = r;
    exp_q.push_back(it); -> sample_ev;
    #1;
  endtask

  task automatic drive(logic [7:0] v);
    @(negedge clk); port_in = v; settle(5);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3); rst = 0; settle(2);
    rd(0, 32'h0, "R1"); pin(1, 0, "R1"); pin(2, 0, "R1");
    wr(32'hFFFF_FFFF); rd(0, 32'h0000_1060, "R2");
    wr(32'h0); rd(0, 32'h0, "R2");
    // disabled: request edges ignored, all pins visible
    drive(8'h40); drive(8'h00); drive(8'h40);
    rd(0, 32'h0, "R3");
    drive(8'hC5); rd(2, 32'hC5, "R3");
    drive(8'h00);
    wr(32'h1000); drive(8'hC5); rd(2, 32'h05, "R4");
    drive(8'h00);
    // rising, polarity 0, capture off
    drive(8'h4A); rd(0, 32'h0002_1000, "R5");
    pin(1, 1, "R12"); pin(2, 0, "R10");
    wr(32'h1000); rd(0, 32'h0002_1000, "R8");
    wr(32'h0002_1000); rd(0, 32'h1000, "R8");
    drive(8'h00); rd(0, 32'h1000, "R5"); pin(1, 0, "R12");
    // gate high blocks
    drive(8'h80); drive(8'hC0); rd(0, 32'h1000, "R7");
    drive(8'h00);
    // falling polarity with capture
    wr(32'h1060); drive(8'h40); rd(0, 32'h1060, "R6");
    drive(8'h13); rd(0, 32'h0002_1060, "R6");
    rd(1, 32'h13, "R10"); pin(2, 32'h13, "R10");
    // second edge while pending
    drive(8'h5A); drive(8'h24);
    rd(0, 32'h0082_1060, "R9"); rd(1, 32'h13, "R11");
    wr(32'h0080_1060); rd(0, 32'h0002_1060, "R9");
    // enable off keeps pending, drops irq
    wr(32'h0000_0060); pin(1, 0, "R12"); rd(0, 32'h0002_0060, "R12");
    wr(32'h0000_1060); pin(1, 1, "R12");
    wr(32'h0082_1060); rd(0, 32'h1060, "R8");
    drive(8'h40); drive(8'h00); rd(0, 32'h0002_1060, "R6");
    drive(8'h40);
    // coincident clear and new falling edge
    @(negedge clk); port_in = 8'h00;
    @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0002_1060;
    @(negedge clk); reg_wr = 0;
    settle(2);
    rd(0, 32'h0082_1060, "R13"); pin(1, 1, "R13");
    settle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule